// File: doc/BRIEF.md
# Bank-switched dual-port memory

This block is a two-port synchronous memory built from four independent banks of 16-bit words. Each port has its own chip enables, read/write strobe, byte-lane enables, mailbox-steering input, word address and 2-bit bank address. Four external select inputs, one per bank, decide which port owns each bank. A port reaches a bank only while it owns that bank, so the two ports can never reach the same bank in the same cycle, and the block needs no arbitration.

Software on two processors uses the block to pass buffers. One side fills a bank. The select input for that bank is then flipped, and the other side reads the same storage in place. The word address width is a parameter. The full device uses 14 bits (16K words per bank), and a narrower width gives a small array for simulation.

Top module: `bank_dpram`

## Requirements
- R1: While rst_ni is low, and afterwards until a read is granted, both read-data outputs are zero.
- R2: bank_sel_i[b]=0 gives bank b to the left port and 1 gives it to the right port. A write by the owning port is returned by a later read from the same bank and word.
- R3: A write to a bank owned by the other port leaves the contents of that bank unchanged.
- R4: A read of a bank owned by the other port returns zero.
- R5: A port is selected only when ce0_n is 0 and ce1 is 1. When it is not selected, its writes are ignored and its read data is zero.
- R6: When mb_sel_n is 0, the port makes no array access. Its writes are ignored and its read data is zero.
- R7: ub_n (bits 15:8) and lb_n (bits 7:0) are active-low lane enables. A write changes only the enabled lanes, and a read returns zero on the lanes that are not enabled.
- R8: Read data is due in the cycle after the clock edge that captures the address; it does not change before that edge. A granted write cycle (rw_n=0) gives zero read data in the following cycle.
- R9: The banks are independent. The same word address holds separate data in each bank, and the two ports can work on their own banks in the same cycle.
- R10: After a bank's select input is flipped, the new owner reads the data that the previous owner wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 4 | Per-bank owner: 0 left, 1 right |
| l_ce0_n_i | input | 1 | Left chip enable, active low |
| l_ce1_i | input | 1 | Left chip enable, active high |
| l_rw_n_i | input | 1 | Left read (1) / write (0) |
| l_ub_n_i | input | 1 | Left upper lane enable, active low |
| l_lb_n_i | input | 1 | Left lower lane enable, active low |
| l_mb_sel_n_i | input | 1 | Left mailbox steering; 0 blocks array access |
| l_ba_i | input | 2 | Left bank address |
| l_addr_i | input | WORD_AW | Left word address |
| l_wdata_i | input | 16 | Left write data |
| l_rdata_o | output | 16 | Left read data |
| r_ce0_n_i | input | 1 | Right chip enable, active low |
| r_ce1_i | input | 1 | Right chip enable, active high |
| r_rw_n_i | input | 1 | Right read (1) / write (0) |
| r_ub_n_i | input | 1 | Right upper lane enable, active low |
| r_lb_n_i | input | 1 | Right lower lane enable, active low |
| r_mb_sel_n_i | input | 1 | Right mailbox steering; 0 blocks array access |
| r_ba_i | input | 2 | Right bank address |
| r_addr_i | input | WORD_AW | Right word address |
| r_wdata_i | input | 16 | Right write data |
| r_rdata_o | output | 16 | Right read data |

## Verification
Every result of this block appears one clock edge after the inputs that cause it. This applies to read data, to the zero after a write or a refused access, and to the effect of a write on a later read. The bench changes inputs on the falling edge and compares both outputs at the next falling edge, against a reference array and a grant rule. Both are evaluated from the inputs applied before that rising edge. One extra check samples the output between applying a read address and the rising edge, to confirm that nothing shows early. Before the bank selects are flipped and a readback shows the contents untouched, writes from the non-owning side are swept over every word of every bank.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned N_LANES = DATA_W / LANE_W;
  localparam int unsigned N_BANKS = 4;
  localparam int unsigned BA_W    = $clog2(N_BANKS);
  localparam int unsigned N_PORTS = 2;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [N_LANES-1:0] lane_t;
  typedef logic [BA_W-1:0]    bank_t;
  typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;
endpackage

// File: rtl/bdp_port_ctrl.sv
module bdp_port_ctrl
  import bdp_pkg::*;
#(
  parameter port_e PORT = PORT_L
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce0_n_i,
  input  logic               ce1_i,
  input  logic               rw_n_i,
  input  logic               ub_n_i,
  input  logic               lb_n_i,
  input  logic               mb_sel_n_i,
  input  bank_t              ba_i,
  input  logic [N_BANKS-1:0] bank_sel_i,
  input  word_t              bank_rd_i [N_BANKS],
  output logic               acc_o,
  output logic               wr_o,
  output lane_t              be_o,
  output word_t              rdata_o
);
  logic  owns;
  logic  rd_q;
  bank_t ba_q;
  lane_t be_q;

  assign owns  = (bank_sel_i[ba_i] == logic'(PORT));
  assign acc_o = !ce0_n_i && ce1_i && mb_sel_n_i && owns;
  assign wr_o  = !rw_n_i;
  assign be_o  = {~ub_n_i, ~lb_n_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      ba_q <= '0;
      be_q <= '0;
    end else begin
      rd_q <= acc_o && rw_n_i;
      ba_q <= ba_i;
      be_q <= be_o;
    end
  end

  // lane mask on the registered bank word
  always_comb begin
    rdata_o = '0;
    if (rd_q) begin
      for (int i = 0; i < N_LANES; i++) begin
        if (be_q[i]) rdata_o[i*LANE_W +: LANE_W] = bank_rd_i[ba_q][i*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank
  import bdp_pkg::*;
#(
  parameter int unsigned WORD_AW = 6,
  parameter int unsigned BANK_ID = 0,
  localparam int unsigned DEPTH  = 1 << WORD_AW
) (
  input  logic               clk_i,
  input  logic               owner_i,
  input  logic               acc_i   [N_PORTS],
  input  logic               wr_i    [N_PORTS],
  input  lane_t              be_i    [N_PORTS],
  input  bank_t              ba_i    [N_PORTS],
  input  logic [WORD_AW-1:0] addr_i  [N_PORTS],
  input  word_t              wdata_i [N_PORTS],
  output word_t              rd_o
);
  word_t mem [DEPTH];
  word_t rd_q;
  logic  hit;

  // ownership already gates acc_i; only the owner's request is looked at
  assign hit  = acc_i[owner_i] && (ba_i[owner_i] == bank_t'(BANK_ID));
  assign rd_o = rd_q;

  always_ff @(posedge clk_i) begin
    if (hit) begin
      if (wr_i[owner_i]) begin
        for (int i = 0; i < N_LANES; i++) begin
          if (be_i[owner_i][i])
            mem[addr_i[owner_i]][i*LANE_W +: LANE_W] <= wdata_i[owner_i][i*LANE_W +: LANE_W];
        end
      end else begin
        rd_q <= mem[addr_i[owner_i]];
      end
    end
  end
endmodule

// File: rtl/bank_dpram.sv
module bank_dpram
  import bdp_pkg::*;
#(
  parameter int unsigned WORD_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_BANKS-1:0] bank_sel_i,
  input  logic               l_ce0_n_i,
  input  logic               l_ce1_i,
  input  logic               l_rw_n_i,
  input  logic               l_ub_n_i,
  input  logic               l_lb_n_i,
  input  logic               l_mb_sel_n_i,
  input  logic [BA_W-1:0]    l_ba_i,
  input  logic [WORD_AW-1:0] l_addr_i,
  input  logic [DATA_W-1:0]  l_wdata_i,
  output logic [DATA_W-1:0]  l_rdata_o,
  input  logic               r_ce0_n_i,
  input  logic               r_ce1_i,
  input  logic               r_rw_n_i,
  input  logic               r_ub_n_i,
  input  logic               r_lb_n_i,
  input  logic               r_mb_sel_n_i,
  input  logic [BA_W-1:0]    r_ba_i,
  input  logic [WORD_AW-1:0] r_addr_i,
  input  logic [DATA_W-1:0]  r_wdata_i,
  output logic [DATA_W-1:0]  r_rdata_o
);
  logic               ce0_n [N_PORTS];
  logic               ce1   [N_PORTS];
  logic               rw_n  [N_PORTS];
  logic               ub_n  [N_PORTS];
  logic               lb_n  [N_PORTS];
  logic               mb_n  [N_PORTS];
  bank_t              ba    [N_PORTS];
  logic [WORD_AW-1:0] addr  [N_PORTS];
  word_t              wdata [N_PORTS];
  word_t              rdata [N_PORTS];
  logic               acc   [N_PORTS];
  logic               wr    [N_PORTS];
  lane_t              be    [N_PORTS];
  word_t              bank_rd [N_BANKS];

  assign ce0_n = '{l_ce0_n_i, r_ce0_n_i};
  assign ce1   = '{l_ce1_i, r_ce1_i};
  assign rw_n  = '{l_rw_n_i, r_rw_n_i};
  assign ub_n  = '{l_ub_n_i, r_ub_n_i};
  assign lb_n  = '{l_lb_n_i, r_lb_n_i};
  assign mb_n  = '{l_mb_sel_n_i, r_mb_sel_n_i};
  assign ba    = '{l_ba_i, r_ba_i};
  assign addr  = '{l_addr_i, r_addr_i};
  assign wdata = '{l_wdata_i, r_wdata_i};
  assign l_rdata_o = rdata[0];
  assign r_rdata_o = rdata[1];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    bdp_port_ctrl #(
      .PORT(p == 0 ? PORT_L : PORT_R)
    ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ce0_n_i    (ce0_n[p]),
      .ce1_i      (ce1[p]),
      .rw_n_i     (rw_n[p]),
      .ub_n_i     (ub_n[p]),
      .lb_n_i     (lb_n[p]),
      .mb_sel_n_i (mb_n[p]),
      .ba_i       (ba[p]),
      .bank_sel_i (bank_sel_i),
      .bank_rd_i  (bank_rd),
      .acc_o      (acc[p]),
      .wr_o       (wr[p]),
      .be_o       (be[p]),
      .rdata_o    (rdata[p])
    );
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    bdp_bank #(
      .WORD_AW (WORD_AW),
      .BANK_ID (b)
    ) u_bank (
      .clk_i   (clk_i),
      .owner_i (bank_sel_i[b]),
      .acc_i   (acc),
      .wr_i    (wr),
      .be_i    (be),
      .ba_i    (ba),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rd_o    (bank_rd[b])
    );
  end
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk
  import bdp_pkg::*;
#(
  parameter int unsigned WORD_AW = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_BANKS-1:0] bank_sel_i,
  input logic               l_ce0_n_i,
  input logic               l_ce1_i,
  input logic               l_rw_n_i,
  input logic               l_ub_n_i,
  input logic               l_lb_n_i,
  input logic               l_mb_sel_n_i,
  input logic [BA_W-1:0]    l_ba_i,
  input logic [WORD_AW-1:0] l_addr_i,
  input logic [DATA_W-1:0]  l_wdata_i,
  input logic [DATA_W-1:0]  l_rdata_o,
  input logic               r_ce0_n_i,
  input logic               r_ce1_i,
  input logic               r_rw_n_i,
  input logic               r_ub_n_i,
  input logic               r_lb_n_i,
  input logic               r_mb_sel_n_i,
  input logic [BA_W-1:0]    r_ba_i,
  input logic [WORD_AW-1:0] r_addr_i,
  input logic [DATA_W-1:0]  r_wdata_i,
  input logic [DATA_W-1:0]  r_rdata_o
);
  // R5
  l_desel_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ce0_n_i || !l_ce1_i) |=> (l_rdata_o == '0));
  // R5
  r_desel_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_ce0_n_i || !r_ce1_i) |=> (r_rdata_o == '0));
  // R4
  l_foreign_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_sel_i[l_ba_i] |=> (l_rdata_o == '0));
  // R4
  r_foreign_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_sel_i[r_ba_i] |=> (r_rdata_o == '0));
  // R6
  l_mbox_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_mb_sel_n_i |=> (l_rdata_o == '0));
  // R6
  r_mbox_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_mb_sel_n_i |=> (r_rdata_o == '0));
  // R8
  l_wr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rw_n_i |=> (l_rdata_o == '0));
  // R8
  r_wr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rw_n_i |=> (r_rdata_o == '0));
  // R7
  l_lo_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_lb_n_i |=> (l_rdata_o[LANE_W-1:0] == '0));
  // R7
  l_hi_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_ub_n_i |=> (l_rdata_o[DATA_W-1:LANE_W] == '0));
  // R7
  r_lo_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_lb_n_i |=> (r_rdata_o[LANE_W-1:0] == '0));
  // R7
  r_hi_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_ub_n_i |=> (r_rdata_o[DATA_W-1:LANE_W] == '0));
endmodule

bind bank_dpram bdp_chk #(.WORD_AW(WORD_AW)) chk_i (.*);

// File: tb/bank_dpram_tb_top.sv
module bank_dpram_tb_top;
  import bdp_pkg::*;

  localparam int unsigned AW    = 4;
  localparam int unsigned DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_BANKS-1:0] sel = '0;
  logic        ce0_n [2];
  logic        ce1   [2];
  logic        rw_n  [2];
  logic        ub_n  [2];
  logic        lb_n  [2];
  logic        mb_n  [2];
  logic [1:0]  ba    [2];
  logic [AW-1:0] addr [2];
  logic [15:0] wd    [2];
  logic [15:0] rd    [2];
  logic [15:0] ref_mem [N_BANKS][DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5ns clk = ~clk;

  bank_dpram #(.WORD_AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bank_sel_i(sel),
    .l_ce0_n_i(ce0_n[0]), .l_ce1_i(ce1[0]), .l_rw_n_i(rw_n[0]), .l_ub_n_i(ub_n[0]),
    .l_lb_n_i(lb_n[0]), .l_mb_sel_n_i(mb_n[0]), .l_ba_i(ba[0]), .l_addr_i(addr[0]),
    .l_wdata_i(wd[0]), .l_rdata_o(rd[0]),
    .r_ce0_n_i(ce0_n[1]), .r_ce1_i(ce1[1]), .r_rw_n_i(rw_n[1]), .r_ub_n_i(ub_n[1]),
    .r_lb_n_i(lb_n[1]), .r_mb_sel_n_i(mb_n[1]), .r_ba_i(ba[1]), .r_addr_i(addr[1]),
    .r_wdata_i(wd[1]), .r_rdata_o(rd[1])
  );

  function automatic logic [15:0] pat(int b, int a, int s);
    return 16'((b + 1) * 16'h1357 + a * 16'h0241 + s * 16'h4C1D);
  endfunction

  task automatic chk(string tag, int p, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port=%0d actual=%h expected=%h", tag, p, act, exp);
    end
  endtask

  task automatic idle(int p);
    ce0_n[p] = 1'b1; ce1[p] = 1'b0; rw_n[p] = 1'b1; ub_n[p] = 1'b0; lb_n[p] = 1'b0;
    mb_n[p] = 1'b1; ba[p] = '0; addr[p] = '0; wd[p] = '0;
  endtask

  task automatic acc(int p, bit wr, int b, int a, logic [15:0] d);
    ce0_n[p] = 1'b0; ce1[p] = 1'b1; rw_n[p] = !wr; ub_n[p] = 1'b0; lb_n[p] = 1'b0;
    mb_n[p] = 1'b1; ba[p] = 2'(b); addr[p] = AW'(a); wd[p] = d;
  endtask

  function automatic bit granted(int p);
    return !ce0_n[p] && ce1[p] && mb_n[p] && (sel[ba[p]] == 1'(p));
  endfunction

  function automatic logic [15:0] lane_mask(int p);
    return {{8{!ub_n[p]}}, {8{!lb_n[p]}}};
  endfunction

  // inputs already applied at a falling edge; outputs due one rising edge later
  task automatic step(string tag);
    logic [15:0] exp [2];
    for (int p = 0; p < 2; p++)
      exp[p] = (granted(p) && rw_n[p]) ? (ref_mem[ba[p]][addr[p]] & lane_mask(p)) : 16'h0;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(tag, p, rd[p], exp[p]);
      if (granted(p) && !rw_n[p])
        ref_mem[ba[p]][addr[p]] = (ref_mem[ba[p]][addr[p]] & ~lane_mask(p)) | (wd[p] & lane_mask(p));
    end
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(0); idle(1);
    for (int b = 0; b < N_BANKS; b++)
      for (int a = 0; a < DEPTH; a++) ref_mem[b][a] = '0;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", 0, rd[0], 16'h0);
    chk("R1", 1, rd[1], 16'h0);
    rst_ni = 1'b1;
    step("R1");

    // preload every word through the owner so the model starts defined
    sel = 4'h0;
    for (int b = 0; b < N_BANKS; b++)
      for (int a = 0; a < DEPTH; a++) begin
        acc(0, 1, b, a, 16'h0); idle(1); step("R2");
      end

    // left owns all; right writes are refused
    for (int b = 0; b < N_BANKS; b++)
      for (int a = 0; a < DEPTH; a++) begin
        acc(0, 1, b, a, pat(b, a, 1)); acc(1, 1, b, a, ~pat(b, a, 1)); step("R2 R3");
      end
    for (int b = 0; b < N_BANKS; b++)
      for (int a = 0; a < DEPTH; a++) begin
        acc(0, 0, b, a, 16'h0); acc(1, 0, b, a, 16'h0); step("R2 R4 R9");
      end

    // hand all banks to the right
    sel = 4'hF;
    for (int b = 0; b < N_BANKS; b++)
      for (int a = 0; a < DEPTH; a++) begin
        acc(1, 0, b, a, 16'h0); acc(0, 1, b, a, pat(b, a, 7)); step("R10 R3");
      end
    for (int b = 0; b < N_BANKS; b++)
      for (int a = 0; a < DEPTH; a++) begin
        acc(1, 0, b, a, 16'h0); acc(0, 0, b, a, 16'h0); step("R3 R4 R10");
      end

    // split ownership: right has banks 0 and 2, left has 1 and 3
    sel = 4'b0101;
    for (int a = 0; a < DEPTH; a++) begin
      acc(0, 1, 1, a, pat(1, a, 2)); acc(1, 1, 0, a, pat(0, a, 2)); step("R9");
      acc(0, 1, 3, a, pat(3, a, 2)); acc(1, 1, 2, a, pat(2, a, 2)); step("R9");
    end
    for (int a = 0; a < DEPTH; a++) begin
      acc(0, 0, 1, a, 16'h0); acc(1, 0, 0, a, 16'h0); step("R9");
      acc(0, 0, 3, a, 16'h0); acc(1, 0, 2, a, 16'h0); step("R9");
    end

    // chip enable combinations on the left
    sel = 4'h0; idle(1);
    for (int c = 0; c < 4; c++) begin
      acc(0, 1, 0, c, pat(9, c, 3)); ce0_n[0] = c[0]; ce1[0] = c[1]; step("R5");
      acc(0, 0, 0, c, 16'h0); ce0_n[0] = c[0]; ce1[0] = c[1]; step("R5");
      acc(0, 0, 0, c, 16'h0); step("R5");
    end

    // mailbox steering blocks array access
    acc(0, 1, 1, 5, 16'hBEEF); mb_n[0] = 1'b0; step("R6");
    acc(0, 0, 1, 5, 16'h0); mb_n[0] = 1'b0; step("R6");
    acc(0, 0, 1, 5, 16'h0); step("R6");

    // byte lanes
    for (int l = 0; l < 4; l++) begin
      acc(0, 1, 2, l, 16'hC3A5 ^ 16'(l * 16'h1111)); ub_n[0] = !l[1]; lb_n[0] = !l[0]; step("R7");
      acc(0, 0, 2, l, 16'h0); step("R7");
      acc(0, 0, 2, l, 16'h0); ub_n[0] = !l[1]; lb_n[0] = !l[0]; step("R7");
    end

    // read latency: nothing before the capturing edge, data after it
    idle(0); step("R8");
    acc(0, 0, 2, 3, 16'h0);
    #2ns;
    chk("R8", 0, rd[0], 16'h0);
    step("R8");
    acc(0, 1, 2, 3, 16'h1234); step("R8");
    acc(0, 0, 2, 3, 16'h0); step("R8");
    idle(0); step("R8");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule